// File: doc/BRIEF.md
# Prioritised 64-Source Interrupt Arbiter

The block watches 64 level-sensitive request lines and picks one of them to present to a processor core. Each source has an eight-bit control byte that acts both as its priority and as the level passed on to the core. A source takes part in the choice only while its control byte is nonzero. Its pending bit must be set and its mask bit must be clear.

A single 32-bit register port reaches every piece of state. The 64-bit pending, mask and force sets are each split into a high word and a low word. A read-only acknowledge word returns the vector the block is currently presenting. The search for the winner is a combinational compare over all 64 sources. The result is registered once before it drives the level and vector outputs.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset the level output is 0 and the vector output is 24. Both mask words (high at 0x08, low at 0x0C) read 0xFFFFFFFF. Pending, force and control bytes read 0, and the acknowledge word at 0xE0 reads 24.
- R2: Pending bits follow the request lines level-sensitively, one clock after the line changes. The word at 0x04 holds sources 0..31 (bit n is source n) and the word at 0x00 holds sources 32..63 (bit n is source 32+n).
- R3: Writes to the pending words at 0x00 and 0x04 have no effect on the pending state.
- R4: A write to 0x08 replaces mask bits for sources 32..63 only, and a write to 0x0C replaces mask bits for sources 0..31 only. The other half is kept. A set mask bit blocks the source.
- R5: The control byte of source i sits at address 0x40+i and takes write data bits 7:0. A nonzero write enables the source and a zero write disables it, even while its request stays high.
- R6: A source is active only when it is pending (or forced), enabled and unmasked. The force words at 0x10/0x14 have no write path and always read 0.
- R7: Among active sources, the one with the largest control byte wins, and its control byte is driven on the level output.
- R8: When active sources share the largest control byte, the highest-numbered one wins.
- R9: The vector output is the winner's index plus 64, so source 0 gives 64 and source 63 gives 127. With no active source the vector is 24 and the level is 0.
- R10: A read of the acknowledge word at 0xE0 returns the vector currently on the vector output.
- R11: A register write changes the outputs one clock after the write edge, and a request change reaches the outputs two clocks after the edge that samples it.
- R12: Unmapped addresses read 0. Writes to them, to the force words, or to the acknowledge word change neither the outputs nor any readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 64 | Level-sensitive request lines, bit i is source i |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte address |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data for reg_addr, combinational |
| irq_level | output | 8 | Control byte of the winning source, 0 when idle |
| irq_vector | output | 8 | Winner index plus 64, or 24 when idle |

## Verification
The tie cases are the sharpest probe. With two sources holding the same control byte, a comparison written as strict greater-than would hand the request to the lower index and show a vector 20 too small. A disabled source whose request is still high must drop out; a design that kept a separate enable bit loosely coupled to the control byte would keep presenting it. Half-word mask writes are checked against the untouched half, which a design that wrote the full 64 bits would corrupt. Each output change is sampled in the exact cycle it is due, so an extra or missing register stage shows as a stale or early vector.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned CTL_W    = 8;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned VEC_BASE = 64;
  localparam int unsigned VEC_IDLE = 24;

  // Word addresses software decodes; positions are part of the contract.
  localparam logic [ADDR_W-1:0] ADR_PEND_HI = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_PEND_LO = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_MASK_HI = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_MASK_LO = 8'h0C;
  localparam logic [ADDR_W-1:0] ADR_FRC_HI  = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_FRC_LO  = 8'h14;
  localparam logic [ADDR_W-1:0] ADR_CTL_LO  = 8'h40;
  localparam logic [ADDR_W-1:0] ADR_ACK     = 8'hE0;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_PEND_HI,
    RS_PEND_LO,
    RS_MASK_HI,
    RS_MASK_LO,
    RS_FRC_HI,
    RS_FRC_LO,
    RS_CTL,
    RS_ACK
  } reg_sel_e;

endpackage

// File: rtl/irq_arb_rstsync.sv
module irq_arb_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/irq_arb_regs.sv
module irq_arb_regs
  import irq_arb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned N_SRC = 2 * DATA_W,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_SRC-1:0]             irq_req,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [VEC_W-1:0]             ack_vec,
  output logic [DATA_W-1:0]            rd_data,
  output logic [N_SRC-1:0]             pend_o,
  output logic [N_SRC-1:0]             mask_o,
  output logic [N_SRC-1:0]             frc_o,
  output logic [N_SRC-1:0]             en_o,
  output logic [N_SRC-1:0][CTL_W-1:0]  ctl_o
);

  localparam logic [ADDR_W:0] CTL_END = {1'b0, ADR_CTL_LO} + (ADDR_W+1)'(N_SRC);

  reg_sel_e         sel;
  logic [IDX_W-1:0] ctl_idx;
  logic             ctl_hit;

  logic [N_SRC-1:0] pend_q, pend_d;
  logic [N_SRC-1:0] mask_q, mask_d;
  logic             mask_we;
  logic [CTL_W-1:0] ctl_d;
  logic [N_SRC-1:0] ctl_we;

  // Address decode
  always_comb begin
    ctl_hit = (addr >= ADR_CTL_LO) && ({1'b0, addr} < CTL_END);
    ctl_idx = IDX_W'(addr - ADR_CTL_LO);
    sel     = RS_NONE;
    if (ctl_hit) begin
      sel = RS_CTL;
    end else begin
      case (addr)
        ADR_PEND_HI: sel = RS_PEND_HI;
        ADR_PEND_LO: sel = RS_PEND_LO;
        ADR_MASK_HI: sel = RS_MASK_HI;
        ADR_MASK_LO: sel = RS_MASK_LO;
        ADR_FRC_HI:  sel = RS_FRC_HI;
        ADR_FRC_LO:  sel = RS_FRC_LO;
        ADR_ACK:     sel = RS_ACK;
        default:     sel = RS_NONE;
      endcase
    end
  end

  // Pending: level-sensitive copy of the request lines
  always_comb begin
    pend_d = irq_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // Mask: half-word writes
  always_comb begin
    mask_d  = mask_q;
    mask_we = 1'b0;
    if (wr_en && sel == RS_MASK_HI) begin
      mask_d[N_SRC-1:DATA_W] = wr_data;
      mask_we = 1'b1;
    end else if (wr_en && sel == RS_MASK_LO) begin
      mask_d[DATA_W-1:0] = wr_data;
      mask_we = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_d;
  end

  // Control bytes, each with an enable implied by a nonzero value
  always_comb begin
    ctl_d = wr_data[CTL_W-1:0];
    for (int i = 0; i < int'(N_SRC); i++) begin
      ctl_we[i] = wr_en && (sel == RS_CTL) && (ctl_idx == IDX_W'(i));
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic [CTL_W-1:0] ctl_q;
    logic             en_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q <= '0;
        en_q  <= 1'b0;
      end else if (ctl_we[g]) begin
        ctl_q <= ctl_d;
        en_q  <= |ctl_d;
      end
    end

    assign ctl_o[g] = ctl_q;
    assign en_o[g]  = en_q;
  end

  // Force set has no write path and stays clear
  assign frc_o  = '0;
  assign pend_o = pend_q;
  assign mask_o = mask_q;

  // Read mux
  always_comb begin
    case (sel)
      RS_PEND_HI: rd_data = pend_q[N_SRC-1:DATA_W];
      RS_PEND_LO: rd_data = pend_q[DATA_W-1:0];
      RS_MASK_HI: rd_data = mask_q[N_SRC-1:DATA_W];
      RS_MASK_LO: rd_data = mask_q[DATA_W-1:0];
      RS_FRC_HI:  rd_data = frc_o[N_SRC-1:DATA_W];
      RS_FRC_LO:  rd_data = frc_o[DATA_W-1:0];
      RS_CTL:     rd_data = DATA_W'(ctl_o[ctl_idx]);
      RS_ACK:     rd_data = DATA_W'(ack_vec);
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/irq_arb_select.sv
module irq_arb_select
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC = 64,
  localparam int unsigned IDX_W = $clog2(N_SRC),
  localparam int unsigned NODES = 2 * N_SRC
) (
  input  logic [N_SRC-1:0]            act,
  input  logic [N_SRC-1:0][CTL_W-1:0] ctl,
  output logic                        win_valid,
  output logic [CTL_W-1:0]            win_lvl,
  output logic [IDX_W-1:0]            win_idx
);

  // Heap-ordered compare tree: leaves at N_SRC..2*N_SRC-1, root at 1.
  // The right child always covers higher indices, so a tie goes right.
  logic             nd_v [NODES];
  logic [CTL_W-1:0] nd_l [NODES];
  logic [IDX_W-1:0] nd_i [NODES];

  always_comb begin
    nd_v[0] = 1'b0;
    nd_l[0] = '0;
    nd_i[0] = '0;
    for (int g = 0; g < int'(N_SRC); g++) begin
      nd_v[N_SRC+g] = act[g];
      nd_l[N_SRC+g] = ctl[g];
      nd_i[N_SRC+g] = IDX_W'(g);
    end
    for (int k = int'(N_SRC) - 1; k >= 1; k--) begin
      if (nd_v[2*k+1] && (!nd_v[2*k] || nd_l[2*k+1] >= nd_l[2*k])) begin
        nd_v[k] = 1'b1;
        nd_l[k] = nd_l[2*k+1];
        nd_i[k] = nd_i[2*k+1];
      end else begin
        nd_v[k] = nd_v[2*k];
        nd_l[k] = nd_l[2*k];
        nd_i[k] = nd_i[2*k];
      end
    end
  end

  assign win_valid = nd_v[1];
  assign win_lvl   = nd_l[1];
  assign win_idx   = nd_i[1];

endmodule

// File: rtl/irq_arb_outreg.sv
module irq_arb_outreg
  import irq_arb_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  input  logic [CTL_W-1:0] win_lvl,
  input  logic [IDX_W-1:0] win_idx,
  output logic [CTL_W-1:0] level_o,
  output logic [VEC_W-1:0] vector_o
);

  logic [CTL_W-1:0] level_q, level_d;
  logic [VEC_W-1:0] vector_q, vector_d;
  logic             upd_en;

  always_comb begin
    upd_en = 1'b1;
    if (win_valid) begin
      level_d  = win_lvl;
      vector_d = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    end else begin
      level_d  = '0;
      vector_d = VEC_W'(VEC_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      vector_q <= VEC_W'(VEC_IDLE);
    end else if (upd_en) begin
      level_q  <= level_d;
      vector_q <= vector_d;
    end
  end

  assign level_o  = level_q;
  assign vector_o = vector_q;

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned N_SRC = 2 * DATA_W,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic [CTL_W-1:0]  irq_level,
  output logic [VEC_W-1:0]  irq_vector
);

  logic                        srst_n;
  logic [N_SRC-1:0]            pend_w;
  logic [N_SRC-1:0]            mask_w;
  logic [N_SRC-1:0]            frc_w;
  logic [N_SRC-1:0]            en_w;
  logic [N_SRC-1:0][CTL_W-1:0] ctl_w;
  logic [N_SRC-1:0]            act_w;
  logic                        win_valid;
  logic [CTL_W-1:0]            win_lvl;
  logic [IDX_W-1:0]            win_idx;

  irq_arb_rstsync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  irq_arb_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (srst_n),
    .irq_req (irq_req),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wr_data (reg_wr_data),
    .ack_vec (irq_vector),
    .rd_data (reg_rd_data),
    .pend_o  (pend_w),
    .mask_o  (mask_w),
    .frc_o   (frc_w),
    .en_o    (en_w),
    .ctl_o   (ctl_w)
  );

  assign act_w = (pend_w | frc_w) & en_w & ~mask_w;

  irq_arb_select #(.N_SRC(N_SRC)) u_sel (
    .act       (act_w),
    .ctl       (ctl_w),
    .win_valid (win_valid),
    .win_lvl   (win_lvl),
    .win_idx   (win_idx)
  );

  irq_arb_outreg #(.IDX_W(IDX_W)) u_out (
    .clk       (clk),
    .rst_n     (srst_n),
    .win_valid (win_valid),
    .win_lvl   (win_lvl),
    .win_idx   (win_idx),
    .level_o   (irq_level),
    .vector_o  (irq_vector)
  );

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned N_SRC = 2 * DATA_W,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input logic              clk,
  input logic              srst_n,
  input logic [N_SRC-1:0]  irq_req,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic [N_SRC-1:0]  pend,
  input logic [N_SRC-1:0]  mask,
  input logic [N_SRC-1:0]  en,
  input logic [CTL_W-1:0]  irq_level,
  input logic [VEC_W-1:0]  irq_vector
);

  localparam logic [ADDR_W:0] CTL_END = {1'b0, ADR_CTL_LO} + (ADDR_W+1)'(N_SRC);

  logic             ctl_wr;
  logic [IDX_W-1:0] cidx;
  logic [IDX_W-1:0] widx;
  logic [N_SRC-1:0] en_p;
  logic [N_SRC-1:0] mask_p;
  logic [IDX_W-1:0] cidx_p;
  logic [CTL_W-1:0] cdat_p;

  assign ctl_wr = reg_wr_en && (reg_addr >= ADR_CTL_LO) && ({1'b0, reg_addr} < CTL_END);
  assign cidx   = IDX_W'(reg_addr - ADR_CTL_LO);
  assign widx   = IDX_W'(irq_vector - VEC_W'(VEC_BASE));

  always_ff @(posedge clk) begin
    en_p   <= en;
    mask_p <= mask;
    cidx_p <= cidx;
    cdat_p <= reg_wr_data[CTL_W-1:0];
  end

  // R2
  pend_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $past(srst_n) |-> (pend == $past(irq_req)));

  // R4
  mask_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_wr_en && reg_addr == ADR_MASK_LO) |=> $stable(mask[N_SRC-1:DATA_W]));

  // R4
  mask_hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_wr_en && reg_addr == ADR_MASK_HI) |=> $stable(mask[DATA_W-1:0]));

  // R5
  ctl_enable_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ctl_wr |=> (en[cidx_p] == (cdat_p != '0)));

  // R9
  idle_pair_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_vector == VEC_W'(VEC_IDLE)) |-> (irq_level == '0));

  // R9
  busy_vector_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_level != '0) |-> (irq_vector >= VEC_W'(VEC_BASE)));

  // R6
  winner_allowed_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(srst_n) && irq_level != '0) |-> (en_p[widx] && !mask_p[widx]));

endmodule

bind irq_prio_arbiter irq_arb_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .irq_req     (irq_req),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_wr_data (reg_wr_data),
  .pend        (pend_w),
  .mask        (mask_w),
  .en          (en_w),
  .irq_level   (irq_level),
  .irq_vector  (irq_vector)
);

// File: tb/irq_prio_arbiter_tb.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb;

  logic        clk;
  logic        rst_n;
  logic [63:0] irq_req;
  logic        reg_wr_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wr_data;
  logic [31:0] reg_rd_data;
  logic [7:0]  irq_level;
  logic [7:0]  irq_vector;

  int checks;
  int errors;
  bit done;

  irq_prio_arbiter u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .irq_level   (irq_level),
    .irq_vector  (irq_vector)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en   = 1'b1;
    reg_addr    = a;
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rd_data, exp, tag);
  endtask

  task automatic outs(input logic [7:0] lvl, input logic [7:0] vec, input string tag);
    chk({24'd0, irq_level}, {24'd0, lvl}, {tag, " level"});
    chk({24'd0, irq_vector}, {24'd0, vec}, {tag, " vector"});
  endtask

  task automatic t_reset;
    outs(8'd0, 8'd24, "R1 reset");
    rd(8'h08, 32'hFFFF_FFFF, "R1 mask hi");
    rd(8'h0C, 32'hFFFF_FFFF, "R1 mask lo");
    rd(8'h00, 32'h0, "R1 pend hi");
    rd(8'h14, 32'h0, "R1 force lo");
    rd(8'h40, 32'h0, "R1 ctl0");
    rd(8'hE0, 32'd24, "R1 ack");
  endtask

  task automatic t_pending;
    @(negedge clk);
    irq_req = 64'h8000_0001_0000_0002;
    @(negedge clk);
    rd(8'h00, 32'h8000_0001, "R2 pend hi");
    rd(8'h04, 32'h0000_0002, "R2 pend lo");
    outs(8'd0, 8'd24, "R6 all masked");
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0);
    rd(8'h04, 32'h0000_0002, "R3 pend lo write ignored");
    rd(8'h00, 32'h8000_0001, "R3 pend hi write ignored");
    irq_req = '0;
    @(negedge clk);
    rd(8'h04, 32'h0, "R2 pend clears");
  endtask

  task automatic t_mask;
    wr(8'h0C, 32'h0000_FFF0);
    rd(8'h0C, 32'h0000_FFF0, "R4 mask lo written");
    rd(8'h08, 32'hFFFF_FFFF, "R4 mask hi kept");
    wr(8'h08, 32'h0);
    rd(8'h0C, 32'h0000_FFF0, "R4 mask lo kept");
    rd(8'h08, 32'h0, "R4 mask hi written");
    wr(8'h0C, 32'h0);
  endtask

  task automatic t_select;
    wr(8'h45, 32'h0000_0103);
    wr(8'h54, 32'h9);
    wr(8'h68, 32'h9);
    rd(8'h45, 32'h3, "R5 ctl5 byte only");
    rd(8'h54, 32'h9, "R5 ctl20 readback");
    @(negedge clk);
    irq_req = (64'd1 << 5) | (64'd1 << 20) | (64'd1 << 40);
    @(negedge clk);
    @(negedge clk);
    outs(8'd9, 8'd104, "R8 tie highest index");
    rd(8'hE0, 32'd104, "R10 ack");
    irq_req = (64'd1 << 5) | (64'd1 << 20);
    @(negedge clk);
    @(negedge clk);
    outs(8'd9, 8'd84, "R7 next highest");
    irq_req = (64'd1 << 5);
    @(negedge clk);
    @(negedge clk);
    outs(8'd3, 8'd69, "R7 lone source");
  endtask

  task automatic t_disable;
    wr(8'h45, 32'h0);
    outs(8'd3, 8'd69, "R11 write latency");
    @(negedge clk);
    outs(8'd0, 8'd24, "R5 zero ctl disables");
    rd(8'hE0, 32'd24, "R10 ack idle");
    rd(8'h45, 32'h0, "R5 ctl5 cleared");
  endtask

  task automatic t_mask_win;
    irq_req = (64'd1 << 63) | 64'd1;
    wr(8'h7F, 32'hFF);
    wr(8'h40, 32'h1);
    @(negedge clk);
    outs(8'hFF, 8'd127, "R9 top source");
    wr(8'h08, 32'h8000_0000);
    @(negedge clk);
    outs(8'd1, 8'd64, "R6 masked loses, R9 source 0");
    wr(8'h08, 32'h0);
    @(negedge clk);
    outs(8'hFF, 8'd127, "R4 unmask");
    irq_req = 64'd1;
    @(negedge clk);
    outs(8'hFF, 8'd127, "R11 request latency early");
    @(negedge clk);
    outs(8'd1, 8'd64, "R11 request latency due");
  endtask

  task automatic t_unmapped;
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'hE0, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    @(negedge clk);
    outs(8'd1, 8'd64, "R12 outputs unchanged");
    rd(8'h20, 32'h0, "R12 unmapped read");
    rd(8'h10, 32'h0, "R6 force hi zero");
    rd(8'h14, 32'h0, "R6 force lo zero");
    rd(8'hE0, 32'd64, "R10 ack current");
    rd(8'h40, 32'h1, "R12 ctl0 intact");
  endtask

  initial begin
    checks      = 0;
    errors      = 0;
    done        = 1'b0;
    rst_n       = 1'b0;
    irq_req     = '0;
    reg_wr_en   = 1'b0;
    reg_addr    = '0;
    reg_wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_pending;
    t_mask;
    t_select;
    t_disable;
    t_mask_win;
    t_unmapped;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule